// File: doc/BRIEF.md
# I2C Master Read Sequencer for 10-bit Slave Addresses

This block is a byte-level I2C master that performs one complete read from a slave with a 10-bit address. A single-cycle `go_i` pulse starts it. With that pulse it takes in the target address and the number of bytes to fetch. It then drives the open-drain enables of SCL and SDA through a START and a two-byte address header in the write direction. It follows with a repeated START, a third header byte in the read direction, the data bytes, and finally a STOP.

The enables are active high: a 1 on `scl_oe_o` or `sda_oe_o` pulls that line low, and a 0 releases it. Each SCL period is built from four quarter phases of `CLK_DIV` system clocks each. The master answers every received byte with ACK except the last, which it answers with NAK. Each received byte appears on `rx_data_o` with a one-cycle `rx_valid_o` strobe. `tx_irq_o` pulses as each outgoing header byte starts shifting. `rx_irq_o` pulses as each data byte is completed.

Top module: `i2c10_rd_master`

## Requirements
- R1: After reset both line enables are 0 (lines released), and `busy_o`, `nak_o`, `rx_valid_o`, `tx_irq_o` and `rx_irq_o` are all 0.
- R2: After the first START the master sends the byte {1,1,1,1,0, addr[9], addr[8], 0}, most significant bit first, and samples the slave's acknowledge while SCL is high in the ninth bit slot (SDA low = ACK).
- R3: The second byte sent is addr[7:0], MSB first.
- R4: After the second byte is acknowledged, the master issues a repeated START. It then sends {1,1,1,1,0, addr[9], addr[8], 1}, which falls in a new frame with no STOP in between.
- R5: The master sends ACK (SDA low) after each received byte except the last, and NAK (SDA released) after the last. A byte count of 0 is handled as 1.
- R6: Exactly one STOP ends each transaction. `busy_o` is 1 from the cycle after an accepted `go_i` until the STOP is complete, then returns to 0.
- R7: `tx_irq_o` pulses once for each header byte, in the cycle its first bit is issued. A fully acknowledged transaction therefore gives three pulses.
- R8: Each data byte, assembled MSB first from SDA, is placed on `rx_data_o` with a one-cycle `rx_valid_o` and a one-cycle `rx_irq_o`, once per byte.
- R9: If any header byte is answered with NAK, the master sets `nak_o`, sends STOP, and receives no data. `nak_o` stays set until the next accepted `go_i` clears it.
- R10: SDA changes while SCL is released only when forming START, repeated START or STOP.
- R11: `go_i` has no effect while `busy_o` is 1: the running transaction's header bytes and byte count are unchanged, and no second transaction follows.
- R12: Every SCL high interval between the first START's falling SCL edge and the STOP lasts exactly 2*CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start command pulse |
| tgt_addr_i | input | 10 | 10-bit slave address, sampled with go_i |
| nbytes_i | input | CNT_W | Number of bytes to read, sampled with go_i (0 reads one) |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Transaction in progress |
| nak_o | output | 1 | Address byte was not acknowledged |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe: rx_data_o holds a new byte |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rx_irq_o | output | 1 | Receive interrupt pulse |

## Verification
The bench builds the block with a quarter-phase length of 3 clocks and a 4-bit byte count. SCL high intervals can therefore be measured against an exact 6-cycle target. The largest count, 15, is reached in a short run, and the zero-count rule is exercised at the other end of the same field. A behavioural slave on the modelled open-drain wires decodes START, STOP and every bit. It can refuse a chosen header byte, so the address-NAK abort is checked alongside full reads at addresses with all-ones and mixed upper bits.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

    localparam int ADDR_W = 10;
    localparam logic [4:0] HDR_PREFIX = 5'b11110;

    typedef enum logic [1:0] {
        SYM_BIT,
        SYM_START,
        SYM_STOP
    } sym_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_TX,
        SQ_RSTART,
        SQ_RX,
        SQ_STOP
    } seq_e;

    function automatic logic [7:0] hdr_byte(input logic [1:0] hi, input logic rd);
        return {HDR_PREFIX, hi, rd};
    endfunction

endpackage

// File: rtl/i2c10_tick.sv
module i2c10_tick #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tk_t;

    tk_t tk_d, tk_q;
    logic wrap;

    always_comb begin
        wrap      = (tk_q.cnt == LAST);
        tk_d      = tk_q;
        tk_d.cnt  = (clr_i || wrap) ? '0 : tk_q.cnt + CW'(1);
        tick_o    = wrap && !clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

    generate
        if (CLK_DIV > 1) begin : g_gap
            // R12: quarter phases never shorter than one divider period
            a_r12_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/i2c10_bitio.sv
module i2c10_bitio
    import i2c10_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_v_i,
    input  sym_e cmd_k_i,
    input  logic cmd_b_i,
    input  logic tick_i,
    input  logic sda_i,
    output logic clr_o,
    output logic busy_o,
    output logic done_o,
    output logic rxbit_o,
    output logic scl_oe_o,
    output logic sda_oe_o
);
    typedef struct packed {
        logic       busy;
        sym_e       kind;
        logic       bitv;
        logic [1:0] ph;
        logic       scl_oe;
        logic       sda_oe;
        logic       rxbit;
        logic       done;
    } bx_t;

    bx_t bx_d, bx_q;

    // returns {scl_oe, sda_oe} for a phase of a symbol
    function automatic logic [1:0] lv(input sym_e k, input logic b,
                                      input logic [1:0] p, input logic scl_now);
        logic [1:0] r;
        case (k)
            SYM_BIT:   r = {(p == 2'd0 || p == 2'd3), ~b};
            SYM_START: case (p)
                           2'd0:    r = {scl_now, 1'b0};
                           2'd1:    r = 2'b00;
                           2'd2:    r = 2'b01;
                           default: r = 2'b11;
                       endcase
            default:   case (p)
                           2'd0:    r = 2'b11;
                           2'd1:    r = 2'b01;
                           default: r = 2'b00;
                       endcase
        endcase
        return r;
    endfunction

    always_comb begin
        bx_d      = bx_q;
        bx_d.done = 1'b0;
        clr_o     = !bx_q.busy && cmd_v_i;
        if (clr_o) begin
            bx_d.busy = 1'b1;
            bx_d.kind = cmd_k_i;
            bx_d.bitv = cmd_b_i;
            bx_d.ph   = 2'd0;
            {bx_d.scl_oe, bx_d.sda_oe} = lv(cmd_k_i, cmd_b_i, 2'd0, bx_q.scl_oe);
        end else if (bx_q.busy && tick_i) begin
            if (bx_q.kind == SYM_BIT && bx_q.ph == 2'd2) bx_d.rxbit = sda_i;
            if (bx_q.ph == 2'd3) begin
                bx_d.busy = 1'b0;
                bx_d.done = 1'b1;
            end else begin
                bx_d.ph = bx_q.ph + 2'd1;
                {bx_d.scl_oe, bx_d.sda_oe} = lv(bx_q.kind, bx_q.bitv, bx_q.ph + 2'd1, bx_q.scl_oe);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bx_q <= '{busy: 1'b0, kind: SYM_BIT, bitv: 1'b1, ph: 2'd0,
                              scl_oe: 1'b0, sda_oe: 1'b0, rxbit: 1'b1, done: 1'b0};
        else        bx_q <= bx_d;
    end

    assign busy_o   = bx_q.busy;
    assign done_o   = bx_q.done;
    assign rxbit_o  = bx_q.rxbit;
    assign scl_oe_o = bx_q.scl_oe;
    assign sda_oe_o = bx_q.sda_oe;

    // R10: with SCL released on both cycles, an SDA change belongs to START or STOP
    a_r10_sda_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!bx_q.scl_oe && !$past(bx_q.scl_oe) && (bx_q.sda_oe != $past(bx_q.sda_oe)))
        |-> (bx_q.kind != SYM_BIT));

endmodule

// File: rtl/i2c10_rd_master.sv
module i2c10_rd_master
    import i2c10_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int CNT_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_i,
    input  logic [ADDR_W-1:0]    tgt_addr_i,
    input  logic [CNT_W-1:0]     nbytes_i,
    input  logic                 sda_i,
    output logic                 scl_oe_o,
    output logic                 sda_oe_o,
    output logic                 busy_o,
    output logic                 nak_o,
    output logic [7:0]           rx_data_o,
    output logic                 rx_valid_o,
    output logic                 tx_irq_o,
    output logic                 rx_irq_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        seq_e              st;
        logic [1:0]        hdr;
        logic [3:0]        bitn;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic              nak;
        logic              busy;
        logic              cmd_v;
        sym_e              cmd_k;
        logic              cmd_b;
        logic              tx_irq;
        logic              rx_irq;
        logic              rx_v;
        logic [7:0]        rx_data;
    } sq_t;

    sq_t sq_d, sq_q;

    logic tick, tk_clr, eng_busy, eng_done, eng_rxbit;
    logic       load_en;
    logic [7:0] load_byte;

    i2c10_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr_i(tk_clr), .tick_o(tick)
    );

    i2c10_bitio u_bit (
        .clk(clk), .rst_n(rst_n),
        .cmd_v_i(sq_q.cmd_v), .cmd_k_i(sq_q.cmd_k), .cmd_b_i(sq_q.cmd_b),
        .tick_i(tick), .sda_i(sda_i),
        .clr_o(tk_clr), .busy_o(eng_busy), .done_o(eng_done), .rxbit_o(eng_rxbit),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
    );

    always_comb begin
        sq_d        = sq_q;
        sq_d.cmd_v  = 1'b0;
        sq_d.tx_irq = 1'b0;
        sq_d.rx_irq = 1'b0;
        sq_d.rx_v   = 1'b0;
        load_en     = 1'b0;
        load_byte   = '0;
        case (sq_q.st)
            SQ_IDLE: if (go_i) begin
                sq_d.st    = SQ_START;
                sq_d.busy  = 1'b1;
                sq_d.nak   = 1'b0;
                sq_d.addr  = tgt_addr_i;
                sq_d.left  = (nbytes_i == '0) ? ONE : nbytes_i;
                sq_d.cmd_v = 1'b1;
                sq_d.cmd_k = SYM_START;
            end
            SQ_START: if (eng_done) begin
                sq_d.st   = SQ_TX;
                sq_d.hdr  = 2'd0;
                load_en   = 1'b1;
                load_byte = hdr_byte(sq_q.addr[9:8], 1'b0);
            end
            SQ_TX: if (eng_done) begin
                if (sq_q.bitn < 4'd7) begin
                    sq_d.sh    = {sq_q.sh[6:0], 1'b0};
                    sq_d.bitn  = sq_q.bitn + 4'd1;
                    sq_d.cmd_v = 1'b1;
                    sq_d.cmd_k = SYM_BIT;
                    sq_d.cmd_b = sq_q.sh[6];
                end else if (sq_q.bitn == 4'd7) begin
                    sq_d.bitn  = 4'd8;
                    sq_d.cmd_v = 1'b1;
                    sq_d.cmd_k = SYM_BIT;
                    sq_d.cmd_b = 1'b1;
                end else if (eng_rxbit) begin
                    sq_d.nak   = 1'b1;
                    sq_d.st    = SQ_STOP;
                    sq_d.cmd_v = 1'b1;
                    sq_d.cmd_k = SYM_STOP;
                end else if (sq_q.hdr == 2'd0) begin
                    sq_d.hdr  = 2'd1;
                    load_en   = 1'b1;
                    load_byte = sq_q.addr[7:0];
                end else if (sq_q.hdr == 2'd1) begin
                    sq_d.st    = SQ_RSTART;
                    sq_d.cmd_v = 1'b1;
                    sq_d.cmd_k = SYM_START;
                end else begin
                    sq_d.st    = SQ_RX;
                    sq_d.bitn  = 4'd0;
                    sq_d.cmd_v = 1'b1;
                    sq_d.cmd_k = SYM_BIT;
                    sq_d.cmd_b = 1'b1;
                end
            end
            SQ_RSTART: if (eng_done) begin
                sq_d.st   = SQ_TX;
                sq_d.hdr  = 2'd2;
                load_en   = 1'b1;
                load_byte = hdr_byte(sq_q.addr[9:8], 1'b1);
            end
            SQ_RX: if (eng_done) begin
                sq_d.cmd_v = 1'b1;
                sq_d.cmd_k = SYM_BIT;
                sq_d.cmd_b = 1'b1;
                if (sq_q.bitn < 4'd8) begin
                    sq_d.sh   = {sq_q.sh[6:0], eng_rxbit};
                    sq_d.bitn = sq_q.bitn + 4'd1;
                    if (sq_q.bitn == 4'd7) begin
                        sq_d.rx_data = {sq_q.sh[6:0], eng_rxbit};
                        sq_d.rx_v    = 1'b1;
                        sq_d.rx_irq  = 1'b1;
                        sq_d.cmd_b   = (sq_q.left == ONE);
                    end
                end else if (sq_q.left == ONE) begin
                    sq_d.st    = SQ_STOP;
                    sq_d.cmd_k = SYM_STOP;
                end else begin
                    sq_d.left = sq_q.left - ONE;
                    sq_d.bitn = 4'd0;
                end
            end
            SQ_STOP: if (eng_done) begin
                sq_d.st   = SQ_IDLE;
                sq_d.busy = 1'b0;
            end
            default: sq_d.st = SQ_IDLE;
        endcase
        if (load_en) begin
            sq_d.sh     = load_byte;
            sq_d.bitn   = 4'd0;
            sq_d.cmd_v  = 1'b1;
            sq_d.cmd_k  = SYM_BIT;
            sq_d.cmd_b  = load_byte[7];
            sq_d.tx_irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{st: SQ_IDLE, hdr: 2'd0, bitn: 4'd0, sh: 8'd0, addr: '0,
                              left: '0, nak: 1'b0, busy: 1'b0, cmd_v: 1'b0, cmd_k: SYM_BIT,
                              cmd_b: 1'b1, tx_irq: 1'b0, rx_irq: 1'b0, rx_v: 1'b0,
                              rx_data: 8'd0};
        else        sq_q <= sq_d;
    end

    assign busy_o     = sq_q.busy;
    assign nak_o      = sq_q.nak;
    assign rx_data_o  = sq_q.rx_data;
    assign rx_valid_o = sq_q.rx_v;
    assign tx_irq_o   = sq_q.tx_irq;
    assign rx_irq_o   = sq_q.rx_irq;

    // R11: a command during a transaction leaves the latched address alone
    a_r11_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.busy && go_i) |=> $stable(sq_q.addr));

    // R6: busy only drops when the STOP symbol has finished
    a_r6_busy_ends_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sq_q.busy) |-> $past(sq_q.st == SQ_STOP));

    // R6: the sequencer never hands a symbol to a busy bit engine
    a_r6_cmd_to_idle_engine: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.cmd_v |-> !eng_busy);

    // R9: an address NAK always leads into the STOP state
    a_r9_nak_goes_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sq_q.nak) |-> (sq_q.st == SQ_STOP));

    // R7, R8: transmit and receive interrupts never coincide
    a_r7_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sq_q.tx_irq, sq_q.rx_irq}));

    // R8: a received byte is presented only while the answer bit is pending
    a_r8_valid_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.rx_v |-> (sq_q.st == SQ_RX && sq_q.bitn == 4'd8));

endmodule

// File: tb/sim_i2c10_rd_master.sv
`timescale 1ns/1ps
module sim_i2c10_rd_master;
    localparam int DIV = 3;
    localparam int CW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [9:0] taddr = '0;
    logic [CW-1:0] nb = '0;
    logic scl_oe, sda_oe, busy, nak, rx_v, tx_irq, rx_irq;
    logic [7:0] rx_data;

    logic s_pull = 1'b0;
    wire scl_line = !scl_oe;
    wire sda_line = !(sda_oe || s_pull);

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    i2c10_rd_master #(.CLK_DIV(DIV), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .go_i(go), .tgt_addr_i(taddr), .nbytes_i(nb),
        .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy),
        .nak_o(nak), .rx_data_o(rx_data), .rx_valid_o(rx_v), .tx_irq_o(tx_irq),
        .rx_irq_o(rx_irq)
    );

    function automatic logic [7:0] sdata(input int i);
        return 8'(8'h5A + i * 37);
    endfunction

    // behavioural slave
    logic [7:0] blog [0:255];
    logic       alog [0:255];
    int         flog [0:255];
    int lp = 0, frame = 0, starts = 0, stops = 0, data_idx = 0, nbits = 0;
    int cfg_nak_log = -1;
    logic reading = 1'b0;
    logic [7:0] sh = '0;
    logic pscl = 1'b1, psda = 1'b1;

    always @(scl_line, sda_line) begin
        logic [7:0] tb;
        if (rst_n) begin
            if (pscl && scl_line && psda && !sda_line) begin
                starts++; frame++; nbits = 0; reading = 1'b0; s_pull = 1'b0;
            end else if (pscl && scl_line && !psda && sda_line) begin
                stops++;
            end else if (!pscl && scl_line) begin
                if (nbits < 8) sh = {sh[6:0], sda_line};
                nbits++;
                if (nbits == 9) begin
                    blog[lp] = sh; alog[lp] = sda_line; flog[lp] = frame;
                    if (reading) begin
                        data_idx++;
                        if (sda_line) reading = 1'b0;
                    end else if (sh[0] && !sda_line && (lp == 0 || flog[lp-1] != frame)) begin
                        reading = 1'b1;
                    end
                    lp++; nbits = 0;
                end
            end else if (pscl && !scl_line) begin
                if (nbits == 8) s_pull = reading ? 1'b0 : (lp != cfg_nak_log);
                else if (reading) begin
                    tb = sdata(data_idx);
                    s_pull = !tb[7 - nbits];
                end else s_pull = 1'b0;
            end
        end
        pscl = scl_line;
        psda = sda_line;
    end

    // output monitors
    int txi = 0, rxi = 0, rxn = 0, hi_cnt = 0, hi_meas = 0, hi_bad = 0;
    logic hi_valid = 1'b0;
    logic [7:0] rxbuf [0:255];

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_irq) txi++;
            if (rx_irq) rxi++;
            if (rx_v) begin rxbuf[rxn] = rx_data; rxn++; end
            if (!scl_oe) begin
                hi_cnt++;
                if (!busy) hi_valid = 1'b0;
            end else begin
                if (hi_cnt > 0 && hi_valid) begin
                    hi_meas++;
                    if (hi_cnt != 2 * DIV) hi_bad++;
                end
                hi_cnt = 0;
                hi_valid = 1'b1;
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_go(input logic [9:0] a, input int n);
        @(negedge clk);
        go = 1'b1; taddr = a; nb = CW'(n);
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(scl_oe == 1'b0, "R1 scl_oe", int'(scl_oe), 0);
        chk(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(nak == 1'b0, "R1 nak", int'(nak), 0);
        chk({rx_v, tx_irq, rx_irq} == 3'b0, "R1 strobes", int'({rx_v, tx_irq, rx_irq}), 0);
    endtask

    task automatic t_read(input logic [9:0] a, input int n);
        int s = lp, st0 = starts, sp0 = stops, d0 = data_idx;
        int tx0 = txi, rx0 = rxi, rn0 = rxn, hb0 = hi_bad, hm0 = hi_meas;
        int eff = (n == 0) ? 1 : n;
        pulse_go(a, n);
        chk(busy == 1'b1, "R6 busy after go", int'(busy), 1);
        chk(nak == 1'b0, "R9 nak cleared by go", int'(nak), 0);
        wait_idle();
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R6 busy low after stop", int'(busy), 0);
        chk(lp - s == 3 + eff, "R8 bytes on bus", lp - s, 3 + eff);
        chk(blog[s] == {5'b11110, a[9:8], 1'b0}, "R2 first header", int'(blog[s]), int'({5'b11110, a[9:8], 1'b0}));
        chk(blog[s+1] == a[7:0], "R3 low address byte", int'(blog[s+1]), int'(a[7:0]));
        chk(blog[s+2] == {5'b11110, a[9:8], 1'b1}, "R4 read header", int'(blog[s+2]), int'({5'b11110, a[9:8], 1'b1}));
        chk(flog[s+2] == flog[s] + 1 && flog[s+1] == flog[s], "R4 repeated start frame", flog[s+2] - flog[s], 1);
        chk(starts - st0 == 2, "R4 start count", starts - st0, 2);
        chk(stops - sp0 == 1, "R6 stop count", stops - sp0, 1);
        for (int i = 0; i < eff; i++) begin
            chk(alog[s+3+i] == (i == eff - 1), "R5 master ack bit", int'(alog[s+3+i]), int'(i == eff - 1));
            chk(rxbuf[rn0+i] == sdata(d0 + i), "R8 rx data", int'(rxbuf[rn0+i]), int'(sdata(d0 + i)));
        end
        chk(rxn - rn0 == eff, "R8 rx_valid count", rxn - rn0, eff);
        chk(rxi - rx0 == eff, "R8 rx_irq count", rxi - rx0, eff);
        chk(txi - tx0 == 3, "R7 tx_irq count", txi - tx0, 3);
        chk(hi_bad == hb0 && hi_meas > hm0, "R12 scl high width", hi_bad - hb0, 0);
        chk(starts - st0 == 2 && stops - sp0 == 1, "R10 only start/stop edges", starts - st0 + stops - sp0, 3);
    endtask

    task automatic t_addr_nak();
        int s = lp, st0 = starts, sp0 = stops, tx0 = txi, rn0 = rxn;
        cfg_nak_log = lp + 1;
        pulse_go(10'h155, 3);
        wait_idle();
        repeat (4) @(negedge clk);
        cfg_nak_log = -1;
        chk(nak == 1'b1, "R9 nak flag", int'(nak), 1);
        chk(lp - s == 2, "R9 abort after header", lp - s, 2);
        chk(alog[s+1] == 1'b1, "R9 slave nak seen", int'(alog[s+1]), 1);
        chk(stops - sp0 == 1 && starts - st0 == 1, "R9 stop issued", stops - sp0, 1);
        chk(rxn == rn0, "R9 no data", rxn - rn0, 0);
        chk(txi - tx0 == 2, "R7 tx_irq on abort", txi - tx0, 2);
        chk(busy == 1'b0, "R9 busy released", int'(busy), 0);
    endtask

    task automatic t_busy_ignore();
        int s = lp, st0 = starts, rn0 = rxn;
        pulse_go(10'h0C3, 2);
        repeat (40) @(negedge clk);
        pulse_go(10'h3AA, 5);
        wait_idle();
        repeat (30) @(negedge clk);
        chk(busy == 1'b0, "R11 no second transaction", int'(busy), 0);
        chk(starts - st0 == 2, "R11 start count", starts - st0, 2);
        chk(blog[s+1] == 8'hC3, "R11 address kept", int'(blog[s+1]), 8'hC3);
        chk(rxn - rn0 == 2, "R11 count kept", rxn - rn0, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_read(10'h2A5, 3);
        t_read(10'h3FF, 1);
        t_addr_nak();
        t_read(10'h01E, 2);
        t_read(10'h100, 0);
        t_busy_ignore();
        t_read(10'h27C, 15);
        summary();
        $finish;
    end

endmodule